// File: doc/BRIEF.md
# DMA Byte Count and Burst Pacing Controller

This block sits beside the packet engine of a USB device controller and governs a peripheral-side DMA channel. Software programs a transfer length and a configuration word through a small register port. Setting the run bit arms a working counter from the programmed length. The block then requests data from an external DMA controller one burst at a time, and it counts every byte strobe that the DMA side returns.

A transfer ends in one of two ways. The working count can fall to zero while count-based termination is enabled, or a short or empty OUT packet can arrive while short-packet termination is enabled. In either case the block emits a one-clock end-of-transfer pulse, drops its run flag and holds its request low until software sets the run bit again. A USB bus reset stops the channel but keeps every programmed setting, so a new transfer only needs the run bit written again.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: After the power-up reset, both registers read 0, and `dma_req` and `dma_eot` are low.
- R2: Reading the count register (`reg_sel`=1) returns the bytes remaining in the working counter. A count write changes only the programmed length, which stays invisible until the next run start.
- R3: A configuration write with bit 3 set starts a run and loads the working counter from the programmed length. While running, each `byte_strobe` lowers the working count by one, and the count never goes below 0.
- R4: While running with counter termination (bit 15) set and the working count at 0, `dma_eot` pulses high for exactly one clock and the run flag clears. With bit 15 clear, a zero count ends nothing.
- R5: While running with short-packet termination (bit 14) set, a `short_pkt` pulse causes a `dma_eot` pulse after the next edge and stops the run. With bit 14 clear, `short_pkt` has no effect.
- R6: Burst field codes 0, 1, 2 and 3 (bits 1:0) select bursts of 1, 4, 8 and 16 bytes. `dma_req` rises while running, stays high for the whole burst and falls after the burst's last strobe. With bit 15 set, no new burst starts while the remaining count is below the burst size. With bit 15 clear, bursts keep restarting.
- R7: A configuration write with bit 3 clear stops the run at once, drops `dma_req` and does not pulse `dma_eot`. Strobes arriving while stopped leave the working count unchanged.
- R8: `bus_reset` clears only the run flag and `dma_req`. The bit 15 and bit 14 enables, the endpoint index (bits 7:4), the burst field and the programmed length are all kept.
- R9: The configuration register reads back bit 15, bit 14, bits 7:4, the live run flag at bit 3 and bits 1:0. Every other bit reads 0, and writes to those bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| bus_reset | input | 1 | USB bus reset, one-cycle pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects configuration, 1 selects count |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| byte_strobe | input | 1 | One byte moved by the DMA side |
| short_pkt | input | 1 | Short or empty OUT packet received |
| dma_req | output | 1 | Burst request to the DMA controller |
| dma_eot | output | 1 | One-clock end-of-transfer pulse |

## Verification
The bench builds the block with its default 16-bit counter. This width makes the full register readback meaningful and allows a count of 0x1234 that outlives a bus reset. Small lengths of 2, 6 and 16 bytes are used with burst sizes 1, 4 and 16. These bring the exact-fit burst, the stranded tail below a burst and the saturating zero count within a few cycles. A length of 100 with 8-byte bursts exercises the forced stop in the middle of a burst.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;
  localparam int REG_W     = 16;
  localparam int EP_W      = 4;
  localparam int BURST_W   = 2;
  localparam int BEAT_W    = 5;
  localparam int CNTEN_BIT = 15;
  localparam int SHORT_BIT = 14;
  localparam int EP_LSB    = 4;
  localparam int RUN_BIT   = 3;
  localparam int BURST_LSB = 0;

  typedef struct packed {
    logic              cnt_en;
    logic              short_mode;
    logic [EP_W-1:0]   ep;
    logic [BURST_W-1:0] burst;
  } dma_cfg_t;

  // Burst size in bytes for a burst code: 1, 4, 8, 16
  function automatic logic [BEAT_W-1:0] burst_bytes(input logic [BURST_W-1:0] code);
    logic [BEAT_W-1:0] n;
    case (code)
      2'd0:    n = BEAT_W'(1);
      2'd1:    n = BEAT_W'(4);
      2'd2:    n = BEAT_W'(8);
      default: n = BEAT_W'(16);
    endcase
    return n;
  endfunction

  function automatic dma_cfg_t unpack_cfg(input logic [REG_W-1:0] w);
    dma_cfg_t c;
    c.cnt_en     = w[CNTEN_BIT];
    c.short_mode = w[SHORT_BIT];
    c.ep         = w[EP_LSB +: EP_W];
    c.burst      = w[BURST_LSB +: BURST_W];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] pack_cfg(input dma_cfg_t c, input logic run);
    logic [REG_W-1:0] w;
    w = '0;
    w[CNTEN_BIT]              = c.cnt_en;
    w[SHORT_BIT]              = c.short_mode;
    w[EP_LSB +: EP_W]         = c.ep;
    w[RUN_BIT]                = run;
    w[BURST_LSB +: BURST_W]   = c.burst;
    return w;
  endfunction
endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_xfer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic                cnt_wr,
  input  logic [REG_W-1:0]    wdata,
  output dma_cfg_t            cfg,
  output logic [CNT_W-1:0]    prog_cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '0;
      prog_cnt <= '0;
    end else begin
      if (cfg_wr) cfg      <= unpack_cfg(wdata);
      if (cnt_wr) prog_cnt <= wdata[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/dma_byte_counter.sv
module dma_byte_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] remaining,
  output logic             is_zero
);
  assign is_zero = (remaining == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                remaining <= '0;
    else if (load)             remaining <= load_val;
    else if (dec && !is_zero)  remaining <= remaining - 1'b1;
  end
endmodule

// File: rtl/dma_burst_pacer.sv
module dma_burst_pacer
  import dma_xfer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                halt,
  input  logic                cnt_en,
  input  logic [BURST_W-1:0]  burst_code,
  input  logic [CNT_W-1:0]    remaining,
  input  logic                byte_strobe,
  output logic                req,
  output logic                burst_start,
  output logic                burst_last
);
  logic [BEAT_W-1:0] beats_left;
  logic [BEAT_W-1:0] blen;
  logic              room;

  assign blen        = burst_bytes(burst_code);
  assign room        = !cnt_en || (remaining >= CNT_W'(blen));
  assign burst_start = run && !halt && !req && room;
  assign burst_last  = req && byte_strobe && (beats_left == BEAT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req        <= 1'b0;
      beats_left <= '0;
    end else if (halt || !run) begin
      req        <= 1'b0;
      beats_left <= '0;
    end else if (burst_start) begin
      req        <= 1'b1;
      beats_left <= blen;
    end else if (req && byte_strobe) begin
      beats_left <= beats_left - 1'b1;
      if (burst_last) req <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
  import dma_xfer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_reset,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  input  logic             byte_strobe,
  input  logic             short_pkt,
  output logic             dma_req,
  output logic             dma_eot
);
  dma_cfg_t         cfg;
  logic [CNT_W-1:0] prog_cnt;
  logic [CNT_W-1:0] remaining;
  logic             cnt_zero;
  logic             cfg_wr, cnt_wr, run_load;
  logic             run_q, eot_q;
  logic             eot_cond, eot_fire, halt;
  logic             burst_start, burst_last;

  assign cfg_wr   = reg_wr && !reg_sel;
  assign cnt_wr   = reg_wr && reg_sel;
  assign run_load = cfg_wr && reg_wdata[RUN_BIT] && !bus_reset;

  // termination event seen this cycle, before write/reset priority
  assign eot_cond = run_q && ((cfg.cnt_en && cnt_zero) || (cfg.short_mode && short_pkt));
  assign eot_fire = eot_cond && !bus_reset && !cfg_wr;
  assign halt     = bus_reset || cfg_wr || eot_cond;

  dma_cfg_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cnt_wr   (cnt_wr),
    .wdata    (reg_wdata),
    .cfg      (cfg),
    .prog_cnt (prog_cnt)
  );

  dma_byte_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (run_load),
    .load_val  (prog_cnt),
    .dec       (run_q && byte_strobe),
    .remaining (remaining),
    .is_zero   (cnt_zero)
  );

  dma_burst_pacer #(.CNT_W(CNT_W)) u_pace (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run_q),
    .halt        (halt),
    .cnt_en      (cfg.cnt_en),
    .burst_code  (cfg.burst),
    .remaining   (remaining),
    .byte_strobe (byte_strobe),
    .req         (dma_req),
    .burst_start (burst_start),
    .burst_last  (burst_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      eot_q <= 1'b0;
    end else begin
      eot_q <= eot_fire;
      if (bus_reset)     run_q <= 1'b0;
      else if (cfg_wr)   run_q <= reg_wdata[RUN_BIT];
      else if (eot_fire) run_q <= 1'b0;
    end
  end

  assign dma_eot   = eot_q;
  assign reg_rdata = reg_sel ? REG_W'(remaining) : pack_cfg(cfg, run_q);
endmodule

// File: rtl/dma_xfer_ctrl_chk.sv
module dma_xfer_ctrl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_reset,
  input logic             cfg_wr,
  input logic             byte_strobe,
  input logic             short_pkt,
  input logic             short_mode,
  input logic             run,
  input logic [CNT_W-1:0] remaining,
  input logic             dma_req,
  input logic             dma_eot,
  input logic             burst_last
);
  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && byte_strobe && !cfg_wr && !bus_reset && remaining != '0)
      |=> remaining == $past(remaining) - 1'b1);
  // R4
  eot_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_eot |=> !dma_eot);
  // R4
  eot_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_eot |-> !run);
  // R5
  short_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && short_mode && short_pkt && !cfg_wr && !bus_reset) |=> dma_eot);
  // R6
  burst_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_last |=> !dma_req);
  // R6
  req_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> run);
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cfg_wr) |=> $stable(remaining));
  // R8
  bus_reset_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (!run && !dma_req && !dma_eot));
endmodule

bind dma_xfer_ctrl dma_xfer_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_reset   (bus_reset),
  .cfg_wr      (cfg_wr),
  .byte_strobe (byte_strobe),
  .short_pkt   (short_pkt),
  .short_mode  (cfg.short_mode),
  .run         (run_q),
  .remaining   (remaining),
  .dma_req     (dma_req),
  .dma_eot     (dma_eot),
  .burst_last  (burst_last)
);

// File: tb/tb_dma_xfer_ctrl.sv
`timescale 1ns/1ps
module tb_dma_xfer_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_reset = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        byte_strobe = 1'b0;
  logic        short_pkt = 1'b0;
  logic        dma_req, dma_eot;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    string       tag;
    logic [17:0] exp;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  dma_xfer_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .byte_strobe(byte_strobe), .short_pkt(short_pkt),
    .dma_req(dma_req), .dma_eot(dma_eot)
  );

  function automatic logic [17:0] ex(input logic e, input logic r, input logic [15:0] d);
    return {e, r, d};
  endfunction

  // monitor: compares after each rising edge
  always @(posedge clk) begin
    #1;
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_run++;
      if ({dma_eot, dma_req, reg_rdata} !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got eot=%0b req=%0b data=%h, expected eot=%0b req=%0b data=%h",
                 it.tag, dma_eot, dma_req, reg_rdata, it.exp[17], it.exp[16], it.exp[15:0]);
      end
    end
  end

  // driver: applies one cycle of stimulus and queues the expected outcome
  task automatic step(input logic wr, input logic sel, input logic [15:0] wd,
                      input logic stb, input logic sp, input logic br,
                      input string tag, input logic [17:0] exp);
    reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    byte_strobe = stb; short_pkt = sp; bus_reset = br;
    sb.push_back('{tag, exp});
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    step(0,0,16'h0,0,0,0, "R1 cfg reset",   ex(0,0,16'h0000));
    step(0,1,16'h0,0,0,0, "R1 count reset", ex(0,0,16'h0000));
    // R2 programmed length hidden until run
    step(1,1,16'h0010,0,0,0, "R2 count write hidden", ex(0,0,16'h0000));
    step(0,1,16'h0,0,0,0,    "R2 still hidden",       ex(0,0,16'h0000));
    // R9 reserved bits dropped, run flag live; 16-byte bursts, both enables
    step(1,0,16'hFFFF,0,0,0, "R9 layout readback", ex(0,0,16'hC0FB));
    step(0,1,16'h0,0,0,0,    "R3 reload on run",   ex(0,1,16'h0010));
    for (int i = 1; i <= 16; i++)
      step(0,1,16'h0,1,0,0, "R6 R3 burst16 strobe", ex(0, i < 16, 16'(16 - i)));
    step(0,1,16'h0,0,0,0, "R4 count eot",         ex(1,0,16'h0000));
    step(0,0,16'h0,0,0,0, "R4 eot one clock",     ex(0,0,16'hC0F3));
    // burst of 4, length 6: tail of 2 is stranded
    step(1,1,16'h0006,0,0,0, "R2 count write",   ex(0,0,16'h0000));
    step(1,0,16'h8019,0,0,0, "R9 cfg burst4",    ex(0,0,16'h8019));
    step(0,1,16'h0,0,0,0,    "R3 reload 6",      ex(0,1,16'h0006));
    for (int i = 1; i <= 4; i++)
      step(0,1,16'h0,1,0,0, "R6 burst4 strobe", ex(0, i < 4, 16'(6 - i)));
    step(0,1,16'h0,0,0,0, "R6 no partial burst",   ex(0,0,16'h0002));
    step(0,1,16'h0,1,0,0, "R3 strobe outside req", ex(0,0,16'h0001));
    step(0,1,16'h0,1,0,0, "R3 strobe to zero",     ex(0,0,16'h0000));
    step(0,1,16'h0,0,0,0, "R4 eot after tail",     ex(1,0,16'h0000));
    // 8-byte bursts, no termination enables
    step(1,1,16'd100,0,0,0,  "R2 count write 100", ex(0,0,16'h0000));
    step(1,0,16'h000A,0,0,0, "R9 cfg burst8",      ex(0,0,16'h000A));
    step(0,1,16'h0,0,0,0,    "R3 reload 100",      ex(0,1,16'd100));
    for (int i = 1; i <= 3; i++)
      step(0,1,16'h0,1,0,0, "R6 burst8 strobe", ex(0,1,16'(100 - i)));
    step(0,0,16'h0,0,1,0,    "R5 short ignored",     ex(0,1,16'h000A));
    step(1,0,16'h0002,0,0,0, "R7 forced stop",       ex(0,0,16'h0002));
    step(0,1,16'h0,0,0,0,    "R7 count frozen",      ex(0,0,16'd97));
    step(0,1,16'h0,1,0,0,    "R7 strobe while idle", ex(0,0,16'd97));
    // single-byte bursts, counter termination off
    step(1,1,16'h0002,0,0,0, "R2 count write 2",     ex(0,0,16'd97));
    step(1,0,16'h0008,0,0,0, "R9 cfg single",        ex(0,0,16'h0008));
    step(0,1,16'h0,0,0,0,    "R6 single req",        ex(0,1,16'h0002));
    step(0,1,16'h0,1,0,0,    "R6 single drop",       ex(0,0,16'h0001));
    step(0,1,16'h0,0,0,0,    "R6 re-raise",          ex(0,1,16'h0001));
    step(0,1,16'h0,1,0,0,    "R6 single drop 2",     ex(0,0,16'h0000));
    step(0,1,16'h0,0,0,0,    "R4 no eot when off",   ex(0,1,16'h0000));
    step(0,1,16'h0,1,0,0,    "R3 saturate at zero",  ex(0,0,16'h0000));
    step(0,0,16'h0,0,0,1,    "R8 bus reset stops",   ex(0,0,16'h0000));
    // bus reset keeps settings
    step(1,1,16'h1234,0,0,0, "R2 count write 1234",  ex(0,0,16'h0000));
    step(1,0,16'hC0BD,0,0,0, "R9 cfg with reserved", ex(0,0,16'hC0B9));
    step(0,1,16'h0,0,0,0,    "R3 reload 1234",       ex(0,1,16'h1234));
    step(0,0,16'h0,0,0,1,    "R8 fields kept",       ex(0,0,16'hC0B1));
    step(1,0,16'hC0B9,0,0,0, "R8 rerun",             ex(0,0,16'hC0B9));
    step(0,1,16'h0,0,0,0,    "R8 count kept",        ex(0,1,16'h1234));
    // short packet ends transfer
    step(0,1,16'h0,1,0,0,    "R3 strobe a",          ex(0,1,16'h1233));
    step(0,1,16'h0,1,0,0,    "R3 strobe b",          ex(0,1,16'h1232));
    step(0,1,16'h0,0,1,0,    "R5 short eot",         ex(1,0,16'h1232));
    step(0,0,16'h0,0,0,0,    "R4 stopped after short", ex(0,0,16'hC0B1));
    step(0,0,16'h0,0,0,0,    "R4 no request",        ex(0,0,16'hC0B1));
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule